// File: doc/BRIEF.md
# I2C Target Safe-Disable Status Tracker

This block sits beside the byte-level state machine of an I2C target interface. It decides when a software request to switch the target off actually takes effect. While software holds the enable bit high, the interface is on. When software clears the bit, the block checks what the bus is doing at that moment.

- If the bus is idle, or the traffic concerns another device, the interface turns off on the next clock.
- If the target is in the middle of an address byte, or in a receive transfer addressed to it, the block keeps the interface alive. It asks the bus engine to answer the next acknowledge slot with a NACK. It drops the effective enable once that NACK slot or a STOP condition arrives.

A 3-bit read-only status word records the outcome. Bit 0 mirrors the effective enable. Bit 1 records that the shutdown interrupted target activity. Bit 2 records that bytes of a target-receive transfer addressed to this device were refused. Bits 2:1 are held while the interface stays off, and they are cleared when software enables it again.

Top module: `i2c_tgt_quiesce`

## Requirements
- R1: During and straight after reset, en_eff, force_nack and all three status bits are 0 while sw_en is 0.
- R2: Whenever sw_en is 1, en_eff is 1 in the same cycle, force_nack is 0 and status reads 3'b001.
- R3: status[0] always equals en_eff, and status[2:1] read 0 whenever en_eff is 1.
- R4: If sw_en is sampled 0 at a clock edge while the interface is on and the target is not engaged, en_eff falls at that edge and status reads 3'b000. Not engaged means bus_idle=1, or no address byte in progress and no matched receive transfer, including a matched transmit transfer (dir_rd=1).
- R5: If sw_en is sampled 0 while the target is engaged, en_eff stays 1 and force_nack rises at that edge, and status bit 1 is recorded as 1. Engaged means bus_idle=0 and either addr_phase=1 (either direction, matched or not) or addr_match=1 with dir_rd=0.
- R6: While draining, the first edge that samples ack_slot=1 or stop_seen=1 drops force_nack and en_eff together. A STOP sampled at the same edge as the disable turns the interface off at once, with bit 1 still set.
- R7: Status bit 2 is set when addr_match=1, dir_rd=0 and data_phase=1 are sampled together, either at the disabling edge or during the drain. Bit 2 is never 1 without bit 1.
- R8: While the interface stays off, status is stable. A rising sw_en clears bits 2:1 at the next edge, and they are masked to 0 meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en | input | 1 | Software enable bit |
| bus_idle | input | 1 | Bus free (no transfer between START and STOP) |
| addr_phase | input | 1 | Address byte currently being received |
| addr_match | input | 1 | Received address equals this target's address (held through the transfer) |
| dir_rd | input | 1 | Transfer direction: 1 = target transmits, 0 = target receives |
| data_phase | input | 1 | Data bytes of the transfer are in progress |
| stop_seen | input | 1 | One-cycle pulse on a detected STOP |
| ack_slot | input | 1 | One-cycle pulse at a byte acknowledge slot |
| en_eff | output | 1 | Effective interface enable |
| force_nack | output | 1 | Request to NACK the next acknowledge slot |
| status | output | 3 | {rx data lost, disabled while busy, enabled} |

## Verification
en_eff, force_nack and the status mask respond combinationally to sw_en in the same cycle. Every other result appears right after the clock edge that samples the stimulus: the fall of en_eff, the rise or release of force_nack, and the sticky bits. The bench drives inputs on the falling edge, compares outputs 1 ns later against a cycle model, and only then lets the rising edge advance the model. Each expected value is therefore checked in the exact cycle it becomes due, never earlier or later.

// File: rtl/i2c_tgt_quiesce.sv
module i2c_tgt_quiesce (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_en,
  input  logic       bus_idle,
  input  logic       addr_phase,
  input  logic       addr_match,
  input  logic       dir_rd,
  input  logic       data_phase,
  input  logic       stop_seen,
  input  logic       ack_slot,
  output logic       en_eff,
  output logic       force_nack,
  output logic [2:0] status
);
  typedef enum logic [1:0] {S_OFF = 2'd0, S_ON = 2'd1, S_DRAIN = 2'd2} st_t;

  st_t  st;
  logic busy_q, lost_q;
  logic engaged, rx_data;

  assign rx_data    = addr_match & ~dir_rd & data_phase;
  assign engaged    = ~bus_idle & (addr_phase | (addr_match & ~dir_rd));
  assign en_eff     = sw_en | (st != S_OFF);
  assign force_nack = ~sw_en & (st == S_DRAIN);
  assign status     = {~en_eff & lost_q, ~en_eff & busy_q, en_eff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      busy_q <= 1'b0;
      lost_q <= 1'b0;
    end else if (sw_en) begin
      st <= S_ON;
      if (st != S_ON) begin
        busy_q <= 1'b0;
        lost_q <= 1'b0;
      end
    end else begin
      case (st)
        S_ON: begin
          if (engaged) begin
            busy_q <= 1'b1;
            lost_q <= rx_data;
            st     <= stop_seen ? S_OFF : S_DRAIN;
          end else begin
            st <= S_OFF;
          end
        end
        S_DRAIN: begin
          lost_q <= lost_q | rx_data;
          if (ack_slot | stop_seen) st <= S_OFF;
        end
        default: st <= S_OFF;
      endcase
    end
  end

  p_on_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> (status == 3'b001 && !force_nack));

  p_quiet_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ON && !sw_en && bus_idle) |=> (sw_en || (!en_eff && status == 3'b000)));

  p_addr_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ON && !sw_en && !bus_idle && addr_phase && !stop_seen) |=> (sw_en || (force_nack && en_eff)));

  p_drain_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && !sw_en && (ack_slot || stop_seen)) |=> (sw_en || (!en_eff && !force_nack)));

  p_lost_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[1]);

  p_sticky_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_eff && $past(!en_eff)) |-> $stable(status));

  p_nack_while_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_nack |-> (en_eff && status[2:1] == 2'b00));
endmodule

// File: tb/sim_i2c_tgt_quiesce.sv
`timescale 1ns/1ps
module sim_i2c_tgt_quiesce;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_en = 0, bus_idle = 1, addr_phase = 0, addr_match = 0, dir_rd = 0;
  logic data_phase = 0, stop_seen = 0, ack_slot = 0;
  logic en_eff, force_nack;
  logic [2:0] status;

  int n_cmp = 0, n_bad = 0;
  int m_st = 0;
  logic m_busy = 0, m_lost = 0;

  always #10 clk = ~clk;

  i2c_tgt_quiesce u0 (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .bus_idle(bus_idle),
    .addr_phase(addr_phase), .addr_match(addr_match), .dir_rd(dir_rd),
    .data_phase(data_phase), .stop_seen(stop_seen), .ack_slot(ack_slot),
    .en_eff(en_eff), .force_nack(force_nack), .status(status));

  function automatic logic [4:0] expect_out();
    logic e;
    e = sw_en | (m_st != 0);
    return {e, (m_st == 2) & ~sw_en, ~e & m_lost, ~e & m_busy, e};
  endfunction

  task automatic chk(string tag, logic [4:0] got, logic [4:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {en,nack,status} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic eng, rxd;
    rxd = addr_match & ~dir_rd & data_phase;
    eng = ~bus_idle & (addr_phase | (addr_match & ~dir_rd));
    if (sw_en) begin
      if (m_st != 1) begin m_busy = 0; m_lost = 0; end
      m_st = 1;
    end else if (m_st == 1) begin
      if (eng) begin
        m_busy = 1; m_lost = rxd;
        m_st = stop_seen ? 0 : 2;
      end else m_st = 0;
    end else if (m_st == 2) begin
      m_lost = m_lost | rxd;
      if (ack_slot | stop_seen) m_st = 0;
    end
  endtask

  task automatic step(string tag, logic sw, logic idl, logic ap, logic am,
                      logic rd, logic dp, logic stp, logic ack);
    @(negedge clk);
    sw_en = sw; bus_idle = idl; addr_phase = ap; addr_match = am;
    dir_rd = rd; data_phase = dp; stop_seen = stp; ack_slot = ack;
    #1;
    chk(tag, {en_eff, force_nack, status}, expect_out());
    @(posedge clk);
    model_edge();
  endtask

  task automatic final_check(string tag, logic [4:0] exp);
    @(negedge clk);
    sw_en = 0; bus_idle = 1; addr_phase = 0; addr_match = 0;
    dir_rd = 0; data_phase = 0; stop_seen = 0; ack_slot = 0;
    #1;
    chk(tag, {en_eff, force_nack, status}, exp);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #35;
    chk("R1 in reset", {en_eff, force_nack, status}, 5'b00000);
    rst_n = 1'b1;
    step("R1 after reset", 0, 1, 0, 0, 0, 0, 0, 0);

    // R2/R3: enable forces status 001
    step("R2 enable", 1, 1, 0, 0, 0, 0, 0, 0);
    step("R2 hold", 1, 0, 1, 0, 0, 0, 0, 0);
    // R4: idle disable falls at the sampling edge
    step("R4 idle disable", 0, 1, 0, 0, 0, 0, 0, 0);
    final_check("R4 idle off", 5'b00000);

    // R4: other-device traffic
    step("R2 re-enable", 1, 0, 0, 0, 0, 1, 0, 0);
    step("R4 foreign data", 0, 0, 0, 0, 0, 1, 0, 0);
    final_check("R4 foreign off", 5'b00000);

    // R4: matched transmit data phase
    step("R2 re-enable", 1, 0, 0, 1, 1, 1, 0, 0);
    step("R4 tx data", 0, 0, 0, 1, 1, 1, 0, 0);
    final_check("R4 tx off", 5'b00000);

    // R5/R6: disable during address byte, NACK at ack slot
    step("R2 re-enable", 1, 0, 1, 0, 1, 0, 0, 0);
    step("R5 addr disable", 0, 0, 1, 0, 1, 0, 0, 0);
    step("R5 drain", 0, 0, 1, 1, 1, 0, 0, 0);
    step("R6 ack slot", 0, 0, 0, 1, 1, 0, 0, 1);
    final_check("R5 busy only", 5'b00010);

    // R8: sticky while off
    step("R8 hold", 0, 0, 1, 1, 0, 1, 1, 0);
    step("R8 hold", 0, 1, 0, 0, 0, 0, 0, 1);
    final_check("R8 sticky", 5'b00010);

    // R7: matched receive data phase, NACK later
    step("R8 rise clears", 1, 0, 0, 1, 0, 1, 0, 0);
    step("R7 rx disable", 0, 0, 0, 1, 0, 1, 0, 0);
    step("R7 drain", 0, 0, 0, 1, 0, 1, 0, 0);
    step("R6 nack", 0, 0, 0, 1, 0, 1, 0, 1);
    final_check("R7 lost", 5'b00110);

    // R6: STOP before NACK during drain
    step("R8 rise clears", 1, 0, 1, 0, 0, 0, 0, 0);
    step("R5 addr disable", 0, 0, 1, 0, 0, 0, 0, 0);
    step("R7 data in drain", 0, 0, 0, 1, 0, 1, 0, 0);
    step("R6 stop", 0, 0, 0, 1, 0, 0, 1, 0);
    final_check("R6 stop path", 5'b00110);

    // R6: STOP at disabling edge
    step("R8 rise clears", 1, 0, 0, 1, 0, 0, 0, 0);
    step("R6 stop same edge", 0, 0, 0, 1, 0, 0, 1, 0);
    final_check("R6 immediate", 5'b00010);

    // R8: re-enable during drain masks then clears
    step("R2 re-enable", 1, 0, 1, 0, 0, 0, 0, 0);
    step("R5 addr disable", 0, 0, 1, 0, 0, 0, 0, 0);
    step("R8 re-enable in drain", 1, 0, 1, 0, 0, 0, 0, 0);
    step("R4 idle disable", 0, 1, 0, 0, 0, 0, 0, 0);
    final_check("R8 cleared", 5'b00000);

    // random phase mix checked against the cycle model
    for (int i = 0; i < 4000; i++) begin
      logic sw;
      sw = (m_st == 1) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 4) == 0);
      step("R3/R5/R6/R7 random", sw, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 7) == 0, $urandom_range(0, 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule